// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Tracker

This block sits beside a data cache controller and owns the single reservation used by atomic read-modify-write sequences. A load issued with the reserve flag opens a reservation on the 64-byte line that holds its address. A later conditional store checks its own line against that reservation. If there is no reservation, or it names a different line, the block raises `cancel_store` in the same cycle. The controller uses that signal to suppress the cache array write, to skip the bus cycle and to skip the wait for a store acknowledge. The failed store then completes in the next cycle with a failure status.

Every accepted request produces exactly one completion record, one cycle after it is presented. The record carries `comp_rc`, which is set only for conditional stores, and `comp_done`, which is set for stores that were allowed to write. A snoop or coherence invalidate input removes the reservation at any time. Any conditional store, whether it passes or fails, uses up the reservation.

Top module: `resv_tracker`

## Requirements
- R1: After reset (`rst_n` low, asynchronous) there is no reservation and no completion is presented. A conditional store issued first after reset fails.
- R2: A reserving load records a valid reservation for line `req_addr[ADDR_W-1:6]`. A conditional store to that line then passes: `cancel_store` stays 0, and the next cycle shows `comp_valid`=1, `comp_rc`=1, `comp_done`=1.
- R3: Only line bits take part in the match. Address bits [5:0] are ignored, and a difference in any bit at position 6 or above makes the conditional store fail.
- R4: `cancel_store` is combinational. It is 1 exactly in a cycle holding a valid conditional store that fails, and 0 in every other cycle.
- R5: A failing conditional store completes in the following cycle with `comp_rc`=1 and `comp_done`=0.
- R6: Each valid request produces one completion in the following cycle, and no completion appears otherwise. An ordinary store reports rc=0 and done=1. A load reports rc=0 and done=0.
- R7: Every conditional store clears the reservation, whether it passes or fails.
- R8: `snoop_inval` clears the reservation. If it is high in the same cycle as a conditional store, that store fails. If it is high in the same cycle as a reserving load, no reservation is opened.
- R9: A newer reserving load replaces the recorded line.
- R10: Flag precedence is conditional store, then ordinary store, then reserving load. The reserve flag has no effect on a request that also sets `req_store` or `req_cond`.
- R11: Ordinary stores and non-reserving loads leave the reservation unchanged, whatever their address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_reserve | input | 1 | Load opens a reservation |
| req_store | input | 1 | Request is an ordinary store |
| req_cond | input | 1 | Request is a conditional store |
| snoop_inval | input | 1 | External reservation kill |
| cancel_store | output | 1 | Block the cache write and the bus cycle for this store |
| comp_valid | output | 1 | Completion record valid |
| comp_rc | output | 1 | Completion is for a conditional store |
| comp_done | output | 1 | Store was performed |

## Verification
An external invalidate can arrive in the same cycle as a conditional store or as a reserving load. The bench places `snoop_inval` on the very cycle of each of these requests. It then judges the result from `cancel_store` in that cycle, from the completion record one cycle later, and from the outcome of a follow-up conditional store to the same line. In every collision the invalidate must win: the store fails, or no reservation survives for the following store.

// File: rtl/resv_pkg.sv
package resv_pkg;

  // Decoded request class, in precedence order
  typedef enum logic [2:0] {
    RK_IDLE  = 3'd0,
    RK_LOAD  = 3'd1,
    RK_RSV   = 3'd2,
    RK_STORE = 3'd3,
    RK_COND  = 3'd4
  } req_kind_e;

  typedef struct packed {
    logic valid;
    logic rc;
    logic done;
  } resp_t;

endpackage

// File: rtl/resv_classify.sv
module resv_classify
  import resv_pkg::*;
(
  input  logic      vld,
  input  logic      rsv,
  input  logic      st,
  input  logic      cond,
  output req_kind_e kind
);

  // Conditional store outranks ordinary store, which outranks reserve
  always_comb begin
    if (!vld)      kind = RK_IDLE;
    else if (cond) kind = RK_COND;
    else if (st)   kind = RK_STORE;
    else if (rsv)  kind = RK_RSV;
    else           kind = RK_LOAD;
  end

endmodule

// File: rtl/resv_hold.sv
module resv_hold #(
  parameter int TAG_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] set_tag,
  output logic             hold_valid,
  output logic [TAG_W-1:0] hold_tag
);

  logic             valid_d;
  logic             valid_en;
  logic             tag_en;
  logic [TAG_W-1:0] tag_d;

  // Clearing wins over setting
  always_comb begin
    valid_en = set_en | clr_en;
    valid_d  = set_en & ~clr_en;
    tag_en   = set_en & ~clr_en;
    tag_d    = set_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_valid <= 1'b0;
    else if (valid_en) hold_valid <= valid_d;
  end

  // Line tag is qualified by hold_valid, so it needs no reset
  always_ff @(posedge clk) begin
    if (tag_en) hold_tag <= tag_d;
  end

endmodule

// File: rtl/resv_match.sv
module resv_match #(
  parameter int TAG_W = 26
) (
  input  logic             ref_valid,
  input  logic [TAG_W-1:0] ref_tag,
  input  logic [TAG_W-1:0] cmp_tag,
  output logic             hit
);

  logic [TAG_W-1:0] bit_eq;

  genvar i;
  generate
    for (i = 0; i < TAG_W; i++) begin : g_bit
      assign bit_eq[i] = ~(ref_tag[i] ^ cmp_tag[i]);
    end
  endgenerate

  assign hit = ref_valid & (&bit_eq);

endmodule

// File: rtl/resv_complete.sv
module resv_complete
  import resv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  req_kind_e kind,
  input  logic      fail,
  output resp_t     resp
);

  resp_t resp_d;

  always_comb begin
    resp_d.valid = (kind != RK_IDLE);
    resp_d.rc    = (kind == RK_COND);
    resp_d.done  = (kind == RK_STORE) | ((kind == RK_COND) & ~fail);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resp <= '0;
    else        resp <= resp_d;
  end

endmodule

// File: rtl/resv_tracker.sv
module resv_tracker
  import resv_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_reserve,
  input  logic              req_store,
  input  logic              req_cond,
  input  logic              snoop_inval,
  output logic              cancel_store,
  output logic              comp_valid,
  output logic              comp_rc,
  output logic              comp_done
);

  localparam int LINE_LSB = $clog2(LINE_BYTES);
  localparam int TAG_W    = ADDR_W - LINE_LSB;

  req_kind_e        kind;
  logic [TAG_W-1:0] req_tag;
  logic [TAG_W-1:0] hold_tag;
  logic             hold_valid;
  logic             hit;
  logic             cond_fail;
  logic             set_en;
  logic             clr_en;
  resp_t            resp;
  logic             unused_offset;

  assign req_tag       = req_addr[ADDR_W-1:LINE_LSB];
  assign unused_offset = ^req_addr[LINE_LSB-1:0];

  resv_classify u_cls (
    .vld  (req_valid),
    .rsv  (req_reserve),
    .st   (req_store),
    .cond (req_cond),
    .kind (kind)
  );

  resv_match #(.TAG_W(TAG_W)) u_match (
    .ref_valid (hold_valid),
    .ref_tag   (hold_tag),
    .cmp_tag   (req_tag),
    .hit       (hit)
  );

  // An invalidate in the same cycle defeats a matching reservation
  always_comb begin
    cond_fail = (kind == RK_COND) & ~(hit & ~snoop_inval);
    set_en    = (kind == RK_RSV);
    clr_en    = snoop_inval | (kind == RK_COND);
  end

  resv_hold #(.TAG_W(TAG_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en     (set_en),
    .clr_en     (clr_en),
    .set_tag    (req_tag),
    .hold_valid (hold_valid),
    .hold_tag   (hold_tag)
  );

  resv_complete u_cmp (
    .clk   (clk),
    .rst_n (rst_n),
    .kind  (kind),
    .fail  (cond_fail),
    .resp  (resp)
  );

  assign cancel_store = cond_fail;
  assign comp_valid   = resp.valid;
  assign comp_rc      = resp.rc;
  assign comp_done    = resp.done;

endmodule

// File: rtl/resv_tracker_chk.sv
module resv_tracker_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_store,
  input logic req_cond,
  input logic snoop_inval,
  input logic cancel_store,
  input logic comp_valid,
  input logic comp_rc,
  input logic comp_done
);

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (!comp_valid && !cancel_store);
    end
  end

  assert_cancel_cond_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_store |-> (req_valid && req_cond));

  assert_fail_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_store |=> (comp_valid && comp_rc && !comp_done));

  assert_comp_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> comp_valid);

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !comp_valid);

  assert_plain_rc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_cond) |=> !comp_rc);

  assert_store_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && !req_cond) |=> comp_done);

  assert_cond_consumes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cond) |=> (!(req_valid && req_cond) || cancel_store));

  assert_inval_same_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_inval && req_valid && req_cond) |-> cancel_store);

  assert_inval_prior_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_inval |=> (!(req_valid && req_cond) || cancel_store));

endmodule

bind resv_tracker resv_tracker_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_store    (req_store),
  .req_cond     (req_cond),
  .snoop_inval  (snoop_inval),
  .cancel_store (cancel_store),
  .comp_valid   (comp_valid),
  .comp_rc      (comp_rc),
  .comp_done    (comp_done)
);

// File: tb/sim_resv_tracker.sv
`timescale 1ns/1ps
module sim_resv_tracker;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic          req_reserve;
  logic          req_store;
  logic          req_cond;
  logic          snoop_inval;
  logic          cancel_store;
  logic          comp_valid;
  logic          comp_rc;
  logic          comp_done;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  // Expected completion: {rc, done}
  logic [1:0] exp_q [$];
  string      tag_q [$];

  // Reference reservation, built from the requirements
  bit            m_valid;
  logic [AW-7:0] m_line;

  always #2.5 clk = ~clk;

  resv_tracker u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_reserve  (req_reserve),
    .req_store    (req_store),
    .req_cond     (req_cond),
    .snoop_inval  (snoop_inval),
    .cancel_store (cancel_store),
    .comp_valid   (comp_valid),
    .comp_rc      (comp_rc),
    .comp_done    (comp_done)
  );

  // Monitor: pops one expected record per completion, R6 also on absence
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (comp_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R6 unexpected completion: actual rc=%0b done=%0b expected none",
                   comp_rc, comp_done);
        end else begin
          logic [1:0] e;
          string      t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({comp_rc, comp_done} !== e) begin
            failures++;
            $display("FAIL %s completion: actual rc/done=%b expected %b", t,
                     {comp_rc, comp_done}, e);
          end
        end
      end else if (exp_q.size() != 0) begin
        checks++;
        failures++;
        $display("FAIL R6 missing completion for %s: actual none expected %b",
                 tag_q[0], exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    req_valid   = 1'b0;
    req_reserve = 1'b0;
    req_store   = 1'b0;
    req_cond    = 1'b0;
    snoop_inval = 1'b0;
    req_addr    = '0;
  endtask

  task automatic inval_only(input string t);
    @(negedge clk);
    req_valid   = 1'b0;
    req_reserve = 1'b0;
    req_store   = 1'b0;
    req_cond    = 1'b0;
    snoop_inval = 1'b1;
    #1;
    checks++;
    if (cancel_store !== 1'b0) begin
      failures++;
      $display("FAIL %s cancel without request: actual %b expected 0", t, cancel_store);
    end
    m_valid = 0;
  endtask

  task automatic req(input logic [AW-1:0] a, input bit rsv, input bit st,
                     input bit cnd, input bit inv, input string t);
    bit exp_cancel;
    @(negedge clk);
    req_valid   = 1'b1;
    req_addr    = a;
    req_reserve = rsv;
    req_store   = st;
    req_cond    = cnd;
    snoop_inval = inv;
    #1;
    exp_cancel = cnd && !(m_valid && (m_line == a[AW-1:6]) && !inv);
    checks++;
    if (cancel_store !== exp_cancel) begin
      failures++;
      $display("FAIL %s cancel_store: actual %b expected %b", t, cancel_store, exp_cancel);
    end
    exp_q.push_back({cnd, (cnd && !exp_cancel) || (!cnd && st)});
    tag_q.push_back(t);
    if (inv || cnd) m_valid = 0;
    else if (rsv && !st) begin
      m_valid = 1;
      m_line  = a[AW-1:6];
    end
  endtask

  localparam logic [AW-1:0] LA = 32'h1000_0040;
  localparam logic [AW-1:0] LB = 32'h2000_1180;

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_reserve = 1'b0;
    req_store = 1'b0; req_cond = 1'b0; snoop_inval = 1'b0;
    m_valid = 0; m_line = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (comp_valid !== 1'b0 || cancel_store !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset outputs: actual valid=%b cancel=%b expected 0 0",
               comp_valid, cancel_store);
    end
    rst_n = 1'b1;
    idle();

    req(LA, 0, 0, 1, 0, "R1 cond after reset");
    idle();

    req(LA, 1, 0, 0, 0, "R2 reserve load");
    req(LA + 32'h38, 0, 0, 1, 0, "R2 R3 cond same line offset differs");
    req(LA, 0, 0, 1, 0, "R7 cond after pass");
    idle();

    req(LA, 1, 0, 0, 0, "R3 reserve");
    req(LA + 32'h40, 0, 0, 1, 0, "R3 R5 cond next line");
    req(LA, 0, 0, 1, 0, "R7 cond after fail");

    req(LA, 1, 0, 0, 0, "R8 reserve");
    inval_only("R8 standalone inval");
    req(LA, 0, 0, 1, 0, "R8 cond after inval");

    req(LA, 1, 0, 0, 0, "R8 reserve");
    req(LA, 0, 0, 1, 1, "R8 cond with same-cycle inval");

    req(LA, 1, 0, 0, 1, "R8 reserve with same-cycle inval");
    req(LA, 0, 0, 1, 0, "R8 cond after killed reserve");
    idle();

    req(LA, 1, 0, 0, 0, "R9 reserve A");
    req(LB, 1, 0, 0, 0, "R9 reserve B");
    req(LA, 0, 0, 1, 0, "R9 cond old line");
    req(LB, 1, 0, 0, 0, "R9 reserve B again");
    req(LB + 32'h3f, 0, 0, 1, 0, "R9 cond new line");

    req(LA, 1, 0, 0, 0, "R11 reserve");
    req(LA, 0, 1, 0, 0, "R11 R6 plain store same line");
    req(LB, 0, 0, 0, 0, "R11 R6 plain load");
    req(LB, 0, 1, 0, 0, "R11 plain store other line");
    req(LA + 32'h4, 0, 0, 1, 0, "R11 cond after plain traffic");

    req(LA, 1, 0, 1, 0, "R10 cond with reserve flag");
    req(LA, 0, 0, 1, 0, "R10 cond after cond+reserve");
    req(LA, 1, 1, 0, 0, "R10 store with reserve flag");
    req(LA, 0, 0, 1, 0, "R10 cond after store+reserve");
    idle();
    idle();
    idle();

    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R6 leftover completions: actual %0d expected 0", exp_q.size());
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule